// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between a processor with a 14-bit address bus and two 64K×8 memory devices, one read-only and one RAM. For each access it forms a 16-bit effective address and asserts exactly one device select. The processor space has three regions. The low boot region and the middle region can each be served by either device. The workspace region is always served by RAM. Inside the middle region is a 2K bank window that is relocated onto one of sixteen banked chunks in the upper half of the selected device.

A small mode register picks the device for the low and middle regions, and it can move the workspace to an alternate RAM area. A separate 4-bit register holds the current bank. Software loads both registers through I/O writes. At reset the mode register is preset from three switch inputs.

A display scanner can request a one-byte fetch. A request is granted for a single access slot, and the processor is stalled for that slot. The scanner supplies the low address byte and the high byte is fixed. The scanner is never granted two slots in a row, so a held request alternates with the processor.

Top module: `bank_addr_mapper`

## Requirements
- R1: While reset is low, the mode register takes its three switch inputs and the bank register clears to 0. With all switches at 0, the low region reads from ROM and the middle and workspace regions use RAM.
- R2: A processor access to 0x0000–0x07FF with low_ram=0 selects ROM with access code 2 (loader) and effective address 0x4000 + addr. With low_ram=1 it selects RAM with access code 1 (normal) and effective address equal to addr.
- R3: A processor access to 0x0800–0x17FF uses access code 1 and effective address equal to addr. It selects ROM when mid_rom=1 and RAM otherwise.
- R4: A processor access to the bank window 0x1800–0x1FFF uses access code 0. Its effective address is {1, bank[3:0], addr[10:0]}. It selects ROM when mid_rom=1 and RAM otherwise.
- R5: A processor access to 0x2000–0x3FFF always selects RAM with access code 1. Its effective address is addr + 0x4000 when alt_ws=1 and addr otherwise.
- R6: An I/O write to port 0 loads low_ram from data bit 0, mid_rom from bit 1 and alt_ws from bit 2. A write to port 1 loads the bank from data bits 3:0. Writes to ports 2 and 3 have no effect. A loaded value governs accesses from the next cycle on.
- R7: In a slot granted to the scanner, scan_ack is 1 and the access code is 3. The effective address is {0x3F, scan_addr}. RAM is selected with no write enable, ROM is not selected, and cpu_stall equals cpu_req.
- R8: A scanner request is granted in any cycle unless a grant was given in the cycle before. A request held high is therefore granted on alternate cycles.
- R9: ROM and RAM are never both selected. Neither is selected when there is no granted scan and no cpu_req. ram_we is 1 only for a processor write to a RAM-mapped region, so a write into a ROM-mapped region asserts no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_low_ram | input | 1 | Reset preset: low region from RAM |
| sw_mid_rom | input | 1 | Reset preset: middle region from ROM |
| sw_alt_ws | input | 1 | Reset preset: alternate workspace |
| io_wr | input | 1 | I/O write strobe |
| io_port | input | 2 | I/O port number |
| io_data | input | 4 | I/O write data |
| cpu_req | input | 1 | Processor access valid |
| cpu_wr | input | 1 | Processor access is a write |
| cpu_addr | input | 14 | Processor address |
| cpu_stall | output | 1 | Processor slot taken by scanner |
| scan_req | input | 1 | Scanner fetch request |
| scan_addr | input | 8 | Scanner low address byte |
| scan_ack | output | 1 | Scanner fetch granted this slot |
| acc_mode | output | 2 | Access code: 0 bank, 1 normal, 2 loader, 3 scan |
| ea | output | 16 | Effective memory address |
| rom_cs | output | 1 | ROM select |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |

## Verification
A wrong bit in the mode register shows up at the ports on the first access to the region that bit governs. The symptoms are the wrong device select, bit 14 of the address flipped on workspace accesses, or a loader address where a plain one was expected. A stale or corrupted bank register shows in ea[14:11] on the next bank-window access. A wrong grant-history bit shows up in the same cycle as scan_ack asserted back to back, or as a held request that is refused twice. Because every output is compared against the model on every clock, each such fault is reported in the first cycle in which it becomes visible.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
    localparam int CPU_AW   = 14;
    localparam int MEM_AW   = 16;
    localparam int CHUNK_AW = 11;
    localparam int BANK_W   = 4;
    localparam int IO_PW    = 2;
    localparam int IO_DW    = BANK_W;
    localparam int SCAN_W   = 8;
    localparam int HI_W     = MEM_AW - SCAN_W;
    localparam int CHUNK_W  = MEM_AW - CHUNK_AW;

    localparam logic [IO_PW-1:0]   PORT_MODE    = 2'd0;
    localparam logic [IO_PW-1:0]   PORT_BANK    = 2'd1;
    localparam logic [HI_W-1:0]    SCAN_HI      = 8'h3F;
    localparam logic [CHUNK_W-1:0] LOADER_CHUNK = 5'b01000;

    typedef enum logic [1:0] {
        ACC_BANK = 2'd0,
        ACC_NORM = 2'd1,
        ACC_LOAD = 2'd2,
        ACC_SCAN = 2'd3
    } acc_mode_e;

    typedef enum logic [1:0] {
        RGN_LOW  = 2'd0,
        RGN_MID  = 2'd1,
        RGN_BANK = 2'd2,
        RGN_WS   = 2'd3
    } region_e;

    typedef struct packed {
        logic alt_ws;
        logic mid_rom;
        logic low_ram;
    } mode_t;
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
    import bank_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mode_t             sw_mode,
    input  logic              io_wr,
    input  logic [IO_PW-1:0]  io_port,
    input  logic [IO_DW-1:0]  io_data,
    output mode_t             mode,
    output logic [BANK_W-1:0] bank
);
    typedef struct packed {
        mode_t             mode;
        logic [BANK_W-1:0] bank;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (io_wr) begin
            if (io_port == PORT_MODE) begin
                st_d.mode.low_ram = io_data[0];
                st_d.mode.mid_rom = io_data[1];
                st_d.mode.alt_ws  = io_data[2];
            end else if (io_port == PORT_BANK) begin
                st_d.bank = io_data[BANK_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= sw_mode;
            st_q.bank <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;
    assign bank = st_q.bank;

    // R6
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == PORT_BANK) |=> (bank == $past(io_data[BANK_W-1:0])));
    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_port == PORT_MODE) |=> $stable(mode));
endmodule

// File: rtl/mapper_decode.sv
module mapper_decode
    import bank_map_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  mode_t             mode,
    input  logic              scan_gnt,
    output region_e           region,
    output acc_mode_e         acc,
    output logic              use_rom
);
    always_comb begin
        if (cpu_addr[CPU_AW-1])
            region = RGN_WS;
        else if (cpu_addr[CPU_AW-2:CHUNK_AW] == 2'b00)
            region = RGN_LOW;
        else if (cpu_addr[CPU_AW-2:CHUNK_AW] == 2'b11)
            region = RGN_BANK;
        else
            region = RGN_MID;
    end

    always_comb begin
        acc     = ACC_NORM;
        use_rom = 1'b0;
        if (scan_gnt) begin
            acc = ACC_SCAN;
        end else begin
            unique case (region)
                RGN_LOW: begin
                    use_rom = !mode.low_ram;
                    acc     = mode.low_ram ? ACC_NORM : ACC_LOAD;
                end
                RGN_MID:  use_rom = mode.mid_rom;
                RGN_BANK: begin
                    use_rom = mode.mid_rom;
                    acc     = ACC_BANK;
                end
                default:  use_rom = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/mapper_ea_mux.sv
module mapper_ea_mux
    import bank_map_pkg::*;
(
    input  acc_mode_e         acc,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [SCAN_W-1:0] scan_addr,
    input  logic [BANK_W-1:0] bank,
    input  logic              alt_ws,
    output logic [MEM_AW-1:0] ea
);
    logic [SCAN_W-1:0] ea_lo;
    logic [HI_W-1:0]   ea_hi;
    logic [MEM_AW-1:0] full;

    assign ea_lo = (acc == ACC_SCAN) ? scan_addr : cpu_addr[SCAN_W-1:0];

    always_comb begin
        unique case (acc)
            ACC_BANK: full = {1'b1, bank, cpu_addr[CHUNK_AW-1:0]};
            ACC_LOAD: full = {LOADER_CHUNK, cpu_addr[CHUNK_AW-1:0]};
            ACC_SCAN: full = {SCAN_HI, {SCAN_W{1'b0}}};
            default:  full = {1'b0, alt_ws & cpu_addr[CPU_AW-1], cpu_addr};
        endcase
        ea_hi = full[MEM_AW-1:SCAN_W];
    end

    assign ea = {ea_hi, ea_lo};
endmodule

// File: rtl/bank_addr_mapper.sv
module bank_addr_mapper
    import bank_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_low_ram,
    input  logic              sw_mid_rom,
    input  logic              sw_alt_ws,
    input  logic              io_wr,
    input  logic [IO_PW-1:0]  io_port,
    input  logic [IO_DW-1:0]  io_data,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [CPU_AW-1:0] cpu_addr,
    output logic              cpu_stall,
    input  logic              scan_req,
    input  logic [SCAN_W-1:0] scan_addr,
    output logic              scan_ack,
    output logic [1:0]        acc_mode,
    output logic [MEM_AW-1:0] ea,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic              ram_we
);
    typedef struct packed {
        logic last_gnt;
    } arb_t;

    arb_t      arb_d, arb_q;
    mode_t     sw_mode, mode;
    logic [BANK_W-1:0] bank;
    logic      gnt, use_rom, active;
    region_e   region;
    acc_mode_e acc;

    assign sw_mode = '{alt_ws: sw_alt_ws, mid_rom: sw_mid_rom, low_ram: sw_low_ram};

    mapper_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_mode (sw_mode),
        .io_wr   (io_wr),
        .io_port (io_port),
        .io_data (io_data),
        .mode    (mode),
        .bank    (bank)
    );

    always_comb begin
        gnt            = scan_req && !arb_q.last_gnt;
        arb_d.last_gnt = gnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    mapper_decode u_dec (
        .cpu_addr (cpu_addr),
        .mode     (mode),
        .scan_gnt (gnt),
        .region   (region),
        .acc      (acc),
        .use_rom  (use_rom)
    );

    mapper_ea_mux u_mux (
        .acc       (acc),
        .cpu_addr  (cpu_addr),
        .scan_addr (scan_addr),
        .bank      (bank),
        .alt_ws    (mode.alt_ws),
        .ea        (ea)
    );

    assign active    = gnt || cpu_req;
    assign rom_cs    = active && !gnt && use_rom;
    assign ram_cs    = active && (gnt || !use_rom);
    assign ram_we    = cpu_req && cpu_wr && !gnt && !use_rom;
    assign scan_ack  = gnt;
    assign cpu_stall = gnt && cpu_req;
    assign acc_mode  = acc;

    // R9
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, ram_cs}));
    // R9
    we_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_cs && !scan_ack && cpu_wr));
    // R8
    scan_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_ack |=> !scan_ack);
    // R5
    ws_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !scan_ack && region == RGN_WS) |-> (ram_cs && !rom_cs));
    // R7
    scan_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_ack |-> (ea[SCAN_W-1:0] == scan_addr && ram_cs && !ram_we));
endmodule

// File: tb/bank_addr_mapper_tb.sv
module bank_addr_mapper_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_low_ram = 0, sw_mid_rom = 0, sw_alt_ws = 0;
    logic io_wr = 0;
    logic [1:0] io_port = 0;
    logic [3:0] io_data = 0;
    logic cpu_req = 0, cpu_wr = 0;
    logic [13:0] cpu_addr = 0;
    logic scan_req = 0;
    logic [7:0] scan_addr = 0;
    logic cpu_stall, scan_ack, rom_cs, ram_cs, ram_we;
    logic [1:0] acc_mode;
    logic [15:0] ea;

    int n_vec = 0, n_bad = 0;
    int cyc = 0;
    bit done = 0;

    int m_low_ram, m_mid_rom, m_alt, m_bank, m_last;

    always #5 clk = ~clk;

    bank_addr_mapper u_dut (
        .clk(clk), .rst_n(rst_n),
        .sw_low_ram(sw_low_ram), .sw_mid_rom(sw_mid_rom), .sw_alt_ws(sw_alt_ws),
        .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_stall(cpu_stall),
        .scan_req(scan_req), .scan_addr(scan_addr), .scan_ack(scan_ack),
        .acc_mode(acc_mode), .ea(ea), .rom_cs(rom_cs), .ram_cs(ram_cs), .ram_we(ram_we)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic model_reset();
        m_low_ram = sw_low_ram; m_mid_rom = sw_mid_rom; m_alt = sw_alt_ws;
        m_bank = 0; m_last = 0;
    endtask

    task automatic do_reset(input bit l, input bit m, input bit a);
        @(negedge clk);
        sw_low_ram = l; sw_mid_rom = m; sw_alt_ws = a;
        rst_n = 0; cpu_req = 0; scan_req = 0; io_wr = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    // Drive one cycle, compare with the model before the edge, then advance the model.
    task automatic step(input string force_tag);
        int gnt, e_ea, e_mode, e_rom, e_ram, e_we, e_stall, a;
        string tag;
        a = cpu_addr;
        #4;
        gnt = scan_req && !m_last;
        e_rom = 0; e_ram = 0;
        if (gnt) begin
            e_ea = 'h3F00 + scan_addr; e_mode = 3; e_ram = 1; tag = m_last ? "R8" : "R7";
        end else if (a >= 'h2000) begin
            e_ea = a + (m_alt ? 'h4000 : 0); e_mode = 1; e_ram = 1; tag = "R5";
        end else if (a < 'h800) begin
            tag = "R2";
            if (m_low_ram) begin e_ea = a; e_mode = 1; e_ram = 1; end
            else begin e_ea = 'h4000 + a; e_mode = 2; e_rom = 1; end
        end else if (a >= 'h1800) begin
            e_ea = 'h8000 + m_bank * 'h800 + (a - 'h1800); e_mode = 0; tag = "R4";
            if (m_mid_rom) e_rom = 1; else e_ram = 1;
        end else begin
            e_ea = a; e_mode = 1; tag = "R3";
            if (m_mid_rom) e_rom = 1; else e_ram = 1;
        end
        if (!gnt && !cpu_req) begin e_rom = 0; e_ram = 0; tag = "R9"; end
        e_we = (cpu_req && cpu_wr && !gnt && e_ram) ? 1 : 0;
        if (cpu_req && cpu_wr && !gnt && e_rom) tag = "R9";
        e_stall = (gnt && cpu_req) ? 1 : 0;
        if (force_tag != "") tag = force_tag;
        n_vec++;
        if (ea !== 16'(e_ea) || acc_mode !== 2'(e_mode) || rom_cs !== 1'(e_rom) ||
            ram_cs !== 1'(e_ram) || ram_we !== 1'(e_we) || scan_ack !== 1'(gnt) ||
            cpu_stall !== 1'(e_stall)) begin
            n_bad++;
            $display("FAIL %s: actual ea=%h mode=%0d rom=%b ram=%b we=%b ack=%b stall=%b expected ea=%h mode=%0d rom=%0d ram=%0d we=%0d ack=%0d stall=%0d",
                     tag, ea, acc_mode, rom_cs, ram_cs, ram_we, scan_ack, cpu_stall,
                     16'(e_ea), e_mode, e_rom, e_ram, e_we, gnt, e_stall);
        end
        @(posedge clk);
        m_last = gnt;
        if (io_wr) begin
            if (io_port == 0) begin m_low_ram = io_data[0]; m_mid_rom = io_data[1]; m_alt = io_data[2]; end
            else if (io_port == 1) m_bank = io_data;
        end
        @(negedge clk);
    endtask

    task automatic acc(input logic [13:0] ad, input bit wr, input string t);
        cpu_req = 1; cpu_wr = wr; cpu_addr = ad; scan_req = 0; io_wr = 0;
        step(t);
    endtask

    task automatic iow(input logic [1:0] p, input logic [3:0] d);
        io_wr = 1; io_port = p; io_data = d; cpu_req = 0; scan_req = 0;
        step("R6");
        io_wr = 0;
    endtask

    initial begin
        // R1: all switches low
        do_reset(0, 0, 0);
        acc(14'h0123, 0, "R1");
        acc(14'h0900, 0, "R1");
        acc(14'h1A55, 0, "R1");
        acc(14'h2ABC, 0, "R1");
        cpu_req = 0; step("R9");
        // R9: write into ROM-mapped low region
        acc(14'h0010, 1, "R9");
        // R1: all switches high
        do_reset(1, 1, 1);
        acc(14'h0123, 1, "R1");
        acc(14'h1900, 0, "R1");
        acc(14'h3000, 1, "R1");
        // R6: bank and mode loads, ignored ports
        iow(2'd1, 4'hB);
        acc(14'h1801, 0, "R4");
        iow(2'd2, 4'h5);
        iow(2'd3, 4'h0);
        acc(14'h1FFF, 1, "R6");
        acc(14'h0777, 0, "R6");
        iow(2'd0, 4'b0100);
        acc(14'h3FFF, 1, "R5");
        acc(14'h1234, 1, "R3");
        acc(14'h07FF, 0, "R2");
        // R7/R8: held scan request alternates with processor
        cpu_req = 1; cpu_wr = 1; cpu_addr = 14'h2100;
        for (int i = 0; i < 6; i++) begin
            scan_req = 1; scan_addr = 8'(8'h40 + i);
            step((i % 2) ? "R8" : "R7");
        end
        scan_req = 0;
        // Mixed pseudo-random traffic
        for (int i = 0; i < 4000; i++) begin
            cpu_req   = ($urandom % 4) != 0;
            cpu_wr    = $urandom % 2;
            cpu_addr  = 14'($urandom);
            scan_req  = ($urandom % 3) == 0;
            scan_addr = 8'($urandom);
            io_wr     = ($urandom % 8) == 0;
            io_port   = 2'($urandom);
            io_data   = 4'($urandom);
            step("");
            if (i == 2000) do_reset(0, 1, 0);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule